// File: doc/BRIEF.md
# DMA Pending Request Tracker

This block keeps the request books for one DMA channel. A device raises a one-cycle request strobe each time it wants data moved. The tracker counts every request that has not been serviced yet and shows the channel sequencer when work is waiting. The sequencer reports each finished word with a service pulse. The tracker answers that pulse with an acknowledge strobe to the device, which must complete the word in the same cycle.

In single mode each acknowledged word retires one pending entry. In block mode one request stands for a whole block of words, with its length taken from the transfer count input. The entry is retired only when the final word of that block is acknowledged.

When the auxiliary handshake is on, the device can flag a request as the final one. The tracker then records how far back in the queue that request sits. It raises an early-termination pulse once everything up to and including that request has been serviced. The count saturates instead of wrapping, and a lost request sets a sticky overflow that can raise an interrupt.

Top module: `dma_req_tracker`

## Requirements
- R1: After reset the pending count, pending flag, acknowledge, early-termination pulse and interrupt are all 0.
- R2: A request strobe raises the pending count by one, but only while the channel enable is 1. Requests made while the enable is 0 leave the count unchanged.
- R3: The count, the overflow latch, the word position and the last marker all return to 0 in two cases: the cycle after the clear input is 1, and the cycle after the channel enable goes from 0 to 1. A request in that same cycle is not counted.
- R4: A request accepted in the same cycle as an entry is retired leaves the pending count unchanged.
- R5: The count stops at its maximum (2^CNT_W-1). A request that arrives at the maximum without a retirement in the same cycle is dropped and sets an overflow latch. The latch holds until it is cleared. The interrupt output is the latch ANDed with the overflow interrupt enable.
- R6: The acknowledge output is 1 in exactly one case: the service pulse is 1, the channel is enabled, the count is nonzero, and no clear is happening. In single mode each acknowledge retires one entry.
- R7: In block mode an entry is retired on the N-th acknowledge of its block, where N is the transfer count value. A value of 0 is treated as 1.
- R8: With the auxiliary handshake on and single mode selected, an accepted request carrying the last flag loads the last marker with (count − retire + 1). The marker drops by one on each retirement. The retirement that takes it from 1 to 0 produces a one-cycle early-termination pulse in the next cycle. A newer last request overwrites the marker.
- R9: The last flag has no effect in block mode or when the auxiliary handshake is off. No early-termination pulse follows from it.
- R10: The pending flag is 1 exactly when the pending count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Device request strobe |
| last_i | input | 1 | Marks the request as the final one |
| aux_en_i | input | 1 | Enables the last-request handshake |
| chan_en_i | input | 1 | Channel enable |
| clear_i | input | 1 | Clears the counters |
| block_mode_i | input | 1 | 1 selects block mode |
| xfer_count_i | input | XFER_W | Words per block (0 means 1) |
| svc_done_i | input | 1 | Sequencer has a word serviced |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| pend_count_o | output | CNT_W | Unserviced request count |
| pend_o | output | 1 | Count is nonzero |
| early_term_o | output | 1 | Early-termination pulse |
| ack_o | output | 1 | Device acknowledge strobe |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the tracker with CNT_W=4 and XFER_W=3. A 4-bit count reaches its ceiling of 15 after a short burst of requests, so saturation, dropped requests and the sticky overflow are all tested within a few dozen cycles. The 3-bit transfer count allows block lengths of 3, 7 and the zero-means-one case. The last marker is checked both with retirements in the same cycle and with a later last request that overwrites an earlier one.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // Number of words in one block; a programmed zero means one word.
  function automatic int unsigned block_len(int unsigned xfer);
    return (xfer == 0) ? 1 : xfer;
  endfunction

  // Words still owed on the current block, including the one being acked.
  function automatic int unsigned words_owed(int unsigned wcnt, int unsigned len);
    return (wcnt == 0) ? len : wcnt;
  endfunction

  // Queue position of a newly flagged last request.
  function automatic int unsigned last_position(int unsigned count, bit retire);
    return count - (retire ? 1 : 0) + 1;
  endfunction

  // Pending count after one cycle of accept/retire.
  function automatic int unsigned count_step(int unsigned count, bit accept, bit retire);
    return count + (accept ? 1 : 0) - (retire ? 1 : 0);
  endfunction

endpackage

// File: rtl/dmt_pend_counter.sv
module dmt_pend_counter
  import dmt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_req,
  input  logic             retire,
  output logic [CNT_W-1:0] count,
  output logic             accept,
  output logic             drop
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  assign accept = inc_req & ((count_q != CNT_MAX) | retire);
  assign drop   = inc_req & ~accept;
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (accept || retire) begin
      count_q <= CNT_W'(count_step(int'(count_q), accept, retire));
    end
  end
endmodule

// File: rtl/dmt_block_words.sv
module dmt_block_words
  import dmt_pkg::*;
#(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              block_mode,
  input  logic              ack,
  input  logic [XFER_W-1:0] xfer_count,
  output logic              retire
);
  logic [XFER_W-1:0] wcnt_q;
  logic [XFER_W-1:0] len_w;
  logic [XFER_W-1:0] owed_w;
  logic              final_word_w;

  assign len_w        = XFER_W'(block_len(int'(xfer_count)));
  assign owed_w       = XFER_W'(words_owed(int'(wcnt_q), int'(len_w)));
  assign final_word_w = (owed_w == XFER_W'(1));
  assign retire       = ack & (~block_mode | final_word_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (clr || !block_mode) begin
      wcnt_q <= '0;
    end else if (ack) begin
      wcnt_q <= final_word_w ? '0 : owed_w - XFER_W'(1);
    end
  end
endmodule

// File: rtl/dmt_last_tracker.sv
module dmt_last_tracker #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             retire,
  output logic             term
);
  logic [CNT_W-1:0] mark_q;
  logic             term_q;
  logic             hit_w;

  assign hit_w = retire & (mark_q == CNT_W'(1));
  assign term  = term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
      term_q <= 1'b0;
    end else if (clr) begin
      mark_q <= '0;
      term_q <= 1'b0;
    end else begin
      term_q <= hit_w;
      if (load)
        mark_q <= load_val;
      else if (retire && mark_q != '0)
        mark_q <= mark_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dma_req_tracker.sv
module dma_req_tracker
  import dmt_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              last_i,
  input  logic              aux_en_i,
  input  logic              chan_en_i,
  input  logic              clear_i,
  input  logic              block_mode_i,
  input  logic [XFER_W-1:0] xfer_count_i,
  input  logic              svc_done_i,
  input  logic              ovf_irq_en_i,
  output logic [CNT_W-1:0]  pend_count_o,
  output logic              pend_o,
  output logic              early_term_o,
  output logic              ack_o,
  output logic              irq_o
);
  logic             en_q;
  logic             ovf_q;
  logic             clr_w;
  logic             inc_req_w;
  logic             accept_w;
  logic             drop_w;
  logic             retire_w;
  logic             last_load_w;
  logic [CNT_W-1:0] last_val_w;
  logic [CNT_W-1:0] count_w;

  assign clr_w     = clear_i | (chan_en_i & ~en_q);
  assign inc_req_w = req_i & chan_en_i & ~clr_w;
  assign pend_o    = (count_w != '0);
  assign ack_o     = svc_done_i & chan_en_i & pend_o & ~clr_w;

  dmt_block_words #(.XFER_W(XFER_W)) u_words (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_w),
    .block_mode(block_mode_i),
    .ack       (ack_o),
    .xfer_count(xfer_count_i),
    .retire    (retire_w)
  );

  dmt_pend_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_w),
    .inc_req(inc_req_w),
    .retire (retire_w),
    .count  (count_w),
    .accept (accept_w),
    .drop   (drop_w)
  );

  assign last_load_w = accept_w & last_i & aux_en_i & ~block_mode_i;
  assign last_val_w  = CNT_W'(last_position(int'(count_w), retire_w));

  dmt_last_tracker #(.CNT_W(CNT_W)) u_last (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_w),
    .load    (last_load_w),
    .load_val(last_val_w),
    .retire  (retire_w),
    .term    (early_term_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      en_q <= chan_en_i;
      if (clr_w)
        ovf_q <= 1'b0;
      else if (drop_w)
        ovf_q <= 1'b1;
    end
  end

  assign pend_count_o = count_w;
  assign irq_o        = ovf_q & ovf_irq_en_i;
endmodule

// File: rtl/dma_req_tracker_chk.sv
module dma_req_tracker_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en_i,
  input logic             clear_i,
  input logic             block_mode_i,
  input logic             ack_o,
  input logic             pend_o,
  input logic [CNT_W-1:0] pend_count_o,
  input logic             early_term_o,
  input logic             clr_w,
  input logic             accept_w,
  input logic             retire_w,
  input logic             ovf_q,
  input logic             last_load_w
);
  AST_ACK_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (pend_o && chan_en_i)); // R6
  AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |=> (pend_count_o <= $past(pend_count_o))); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (pend_count_o == '0)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_w) |=> ovf_q); // R5
  AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && retire_w) |=> $stable(pend_count_o)); // R4
  AST_TERM_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    early_term_o |-> $past(ack_o)); // R8
  AST_NO_LAST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    last_load_w |-> !block_mode_i); // R9
endmodule

bind dma_req_tracker dma_req_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en_i   (chan_en_i),
  .clear_i     (clear_i),
  .block_mode_i(block_mode_i),
  .ack_o       (ack_o),
  .pend_o      (pend_o),
  .pend_count_o(pend_count_o),
  .early_term_o(early_term_o),
  .clr_w       (clr_w),
  .accept_w    (accept_w),
  .retire_w    (retire_w),
  .ovf_q       (ovf_q),
  .last_load_w (last_load_w)
);

// File: tb/dma_req_tracker_test.sv
module dma_req_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int XW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, last = 0, aux = 0, en = 0, clr = 0, blk = 0, svc = 0, irqen = 0;
  logic [XW-1:0] xfer = '0;
  logic [CW-1:0] cnt;
  logic pend, term, ack, irq;

  int errors = 0;
  int checks = 0;
  int term_seen = 0;

  // reference model state
  int m_cnt = 0, m_w = 0, m_l = 0, m_enq = 0, m_ovf = 0, m_term = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_tracker #(.CNT_W(CW), .XFER_W(XW)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .last_i(last), .aux_en_i(aux),
    .chan_en_i(en), .clear_i(clr), .block_mode_i(blk), .xfer_count_i(xfer),
    .svc_done_i(svc), .ovf_irq_en_i(irqen), .pend_count_o(cnt), .pend_o(pend),
    .early_term_o(term), .ack_o(ack), .irq_o(irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int c, len, owed, e_ack, e_ret, e_acc, e_drop, load;
    #1;
    c = (clr || (en && !m_enq)) ? 1 : 0;
    e_ack = (svc && en && m_cnt != 0 && !c) ? 1 : 0;
    check("R6 ack", int'(ack), e_ack);
    check("R5 irq", int'(irq), (m_ovf != 0 && irqen) ? 1 : 0);
    len = (xfer == 0) ? 1 : int'(xfer);
    owed = (m_w == 0) ? len : m_w;
    e_ret = (e_ack && (!blk || owed == 1)) ? 1 : 0;
    e_acc = (req && en && !c && (m_cnt < MAXC || e_ret)) ? 1 : 0;
    e_drop = (req && en && !c && !e_acc) ? 1 : 0;
    load = (e_acc && last && aux && !blk) ? 1 : 0;
    @(posedge clk);
    if (c) begin
      m_cnt = 0; m_w = 0; m_l = 0; m_ovf = 0; m_term = 0;
    end else begin
      m_term = (e_ret && m_l == 1) ? 1 : 0;
      if (load) m_l = m_cnt - e_ret + 1;
      else if (e_ret && m_l != 0) m_l = m_l - 1;
      if (!blk) m_w = 0;
      else if (e_ack) m_w = e_ret ? 0 : owed - 1;
      m_cnt = m_cnt + e_acc - e_ret;
      if (e_drop) m_ovf = 1;
    end
    m_enq = int'(en);
    @(negedge clk);
    check("R2 count", int'(cnt), m_cnt);
    check("R10 pend", int'(pend), (m_cnt != 0) ? 1 : 0);
    check("R8 term", int'(term), m_term);
    if (term) term_seen++;
  endtask

  task automatic cyc(logic r, logic l, logic s);
    req = r; last = l; svc = s;
    tick();
    req = 0; last = 0; svc = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int saved;
    repeat (2) @(negedge clk);
    check("R1 count", int'(cnt), 0);
    check("R1 flags", int'({pend, term, ack, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled requests ignored
    cyc(1, 0, 0); cyc(1, 0, 0);
    check("R2 disabled", int'(cnt), 0);
    en = 1; cyc(1, 0, 0);            // enable rising: clear, request lost (R3)
    check("R3 enable rise", int'(cnt), 0);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0);
    check("R2 three counted", int'(cnt), 3);
    // R4: request and service together
    cyc(1, 0, 1);
    check("R4 hold", int'(cnt), 3);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    check("R6 drained", int'(cnt), 0);
    cyc(0, 0, 1);                    // no pending: no ack

    // R5: saturation and overflow
    for (int i = 0; i < MAXC + 2; i++) cyc(1, 0, 0);
    check("R5 saturate", int'(cnt), MAXC);
    check("R5 irq masked", int'(irq), 0);
    irqen = 1; cyc(0, 0, 0);
    check("R5 irq on", int'(irq), 1);
    cyc(0, 0, 1); cyc(1, 0, 0);
    check("R5 sticky", int'(irq), 1);
    clr = 1; cyc(1, 0, 0); clr = 0;
    check("R3 clear", int'(cnt), 0);
    check("R3 irq cleared", int'(irq), 0);

    // R7: block mode, length 3 and 0
    blk = 1; xfer = 3'd3;
    cyc(1, 0, 0); cyc(1, 0, 0);
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R7 mid block", int'(cnt), 2);
    cyc(0, 0, 1);
    check("R7 block done", int'(cnt), 1);
    xfer = 3'd0; cyc(0, 0, 1);
    check("R7 zero len", int'(cnt), 0);
    xfer = 3'd7;
    for (int i = 0; i < 3; i++) cyc(1, 0, 1);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1);

    // R9: last ignored in block mode and without aux
    clr = 1; cyc(0, 0, 0); clr = 0;
    term_seen = 0;
    aux = 1; xfer = 3'd1;
    cyc(1, 1, 0); cyc(0, 0, 1); cyc(0, 0, 0);
    blk = 0; aux = 0;
    cyc(1, 1, 0); cyc(0, 0, 1); cyc(0, 0, 0);
    check("R9 no term", term_seen, 0);

    // R8: last marker
    aux = 1;
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 1); cyc(1, 0, 0);
    term_seen = 0;
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R8 term pulse", term_seen, 1);
    saved = int'(cnt);
    check("R8 later req kept", saved, 1);
    cyc(0, 0, 1);
    // overwrite: second last replaces first
    cyc(1, 1, 0); cyc(1, 0, 0); cyc(1, 1, 0);
    term_seen = 0;
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R8 overwritten", term_seen, 0);
    cyc(0, 0, 1);
    check("R8 overwrite term", term_seen, 1);
    // disable then re-enable clears
    cyc(1, 0, 0); en = 0; cyc(1, 0, 0); en = 1; cyc(0, 0, 0);
    check("R3 re-enable", int'(cnt), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule